// File: doc/BRIEF.md
# Thermal Sensor Auto-Scan Controller

This block polls up to two temperature-sensor converter channels on its own. After enabling, it waits a programmable number of timebase ticks, then asks the converter for one sample per channel in ascending channel order, stores each returned code, and compares it against a per-channel alarm level and a per-channel shutdown level. A level counts as crossed when the stored code is strictly above it (with the default `HOT_UP` = 1; with `HOT_UP` = 0 it counts when the code is strictly below it). While any channel's latest sample crosses either level, the wait between scans uses a second, separate period.

Crossing a level for a programmed number of consecutive samples sets an alarm pending bit, or latches a shutdown condition. Each shutdown can be routed to a reset-unit pin and/or a GPIO pin with a common programmable polarity. Software reaches the block through a simple 32-bit register bus with combinational reads. The converter itself is outside the block and answers a request/acknowledge handshake.

Top module: `thermal_scan_ctrl`

Register offsets: 0x04 control, 0x08 enables/routing, 0x0C pending, 0x20+4n stored code, 0x30+4n alarm level, 0x40+4n shutdown level, 0x60 alarm debounce, 0x64 shutdown debounce, 0x68 normal period, 0x6C hot period.

## Requirements
- R1: After reset, `irq` and `adc_req` are 0. Both shutdown pins sit at their inactive level, which is high because polarity resets to active-low. The control register reads 0, and the alarm debounce register reads 4.
- R2: Once control bit 0 is set, the block waits for the selected period and then requests channel 0 and channel 1 in that order. Each request holds `adc_req` and `adc_chan` steady until `adc_ack`.
- R3: The code taken on `adc_ack` is readable at 0x20+4n, with bits above the code width reading zero. When control bit 1 is set, the stored value is 1024 minus the raw code, truncated to the code width.
- R4: Alarm pending bit n (register 0x0C, bit n) sets only on a sample that is the Nth consecutive crossing of the channel-n alarm level, where N is register 0x60. A sample that does not cross restarts the count.
- R5: `irq` is the OR of pending bits whose enable bit n in 0x08 is set. Writing 0 to a pending bit clears it, and writing 1 leaves it unchanged.
- R6: The gap between scans is register 0x68 ticks while the last samples cross no level. It is register 0x6C ticks once any channel's last sample crosses its alarm or shutdown level.
- R7: When shutdown checking for channel n is on (control bit 4+n), N consecutive crossings of its shutdown level latch a shutdown, where N is register 0x64. The shutdown drives `shut_gpio` when routing bit 4+n of 0x08 is set, and drives `shut_rst` when routing bit 8+n is set. Control bit 8 = 1 makes the pins active-high; 0 makes them active-low.
- R8: With control bit 4+n clear, channel n never activates a shutdown pin, whatever its codes.
- R9: Clearing control bit 0 stops requests, returns both shutdown pins to their inactive level, and restarts the debounce counters and the period timer.
- R10: The period timer advances only on cycles where `tick_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase tick for the period timer |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| adc_req | output | 1 | Sample request to the converter |
| adc_chan | output | CHW | Channel being requested |
| adc_ack | input | 1 | Converter returns `adc_code` this cycle |
| adc_code | input | DW | Raw converter code |
| irq | output | 1 | Alarm interrupt |
| shut_gpio | output | 1 | Shutdown pin toward a GPIO |
| shut_rst | output | 1 | Shutdown pin toward the reset unit |

## Verification
A sample is taken on the clock edge where `adc_ack` is high. The stored code, the pending bit, `irq` and the shutdown pins all change at that same edge, so they are valid one cycle after the acknowledge. The bench's converter model counts completed scans and waits one falling edge past the last acknowledge of a scan before it reads registers or pins. Scan gaps are measured in `tick_en` ticks, counted at the falling edge ahead of each rising edge that uses them, so the measured gap equals the programmed period exactly.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_REQ  = 2'd2
  } sq_state_e;

  localparam logic [7:0] A_CTL  = 8'h04;
  localparam logic [7:0] A_IEN  = 8'h08;
  localparam logic [7:0] A_PEND = 8'h0C;
  localparam logic [7:0] A_DATA = 8'h20;
  localparam logic [7:0] A_ALM  = 8'h30;
  localparam logic [7:0] A_SHT  = 8'h40;
  localparam logic [7:0] A_DBA  = 8'h60;
  localparam logic [7:0] A_DBS  = 8'h64;
  localparam logic [7:0] A_PN   = 8'h68;
  localparam logic [7:0] A_PH   = 8'h6C;
endpackage

// File: rtl/tsc_regs.sv
module tsc_regs
  import tsc_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 12,
  parameter int PW  = 16,
  parameter int DBW = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [7:0]               bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic                     smp_vld,
  input  logic [CHW-1:0]           smp_ch,
  input  logic [DW-1:0]            smp_code,
  input  logic [NCH-1:0]           alarm_set,
  output logic                     ctl_en,
  output logic                     ctl_inv,
  output logic                     ctl_pol,
  output logic [NCH-1:0]           shut_chk,
  output logic [NCH-1:0]           irq_en,
  output logic [NCH-1:0]           route_gpio,
  output logic [NCH-1:0]           route_rst,
  output logic [NCH-1:0]           pend,
  output logic [NCH-1:0][DW-1:0]   thr_alm,
  output logic [NCH-1:0][DW-1:0]   thr_sht,
  output logic [DBW-1:0]           db_alm,
  output logic [DBW-1:0]           db_sht,
  output logic [PW-1:0]            per_norm,
  output logic [PW-1:0]            per_hot
);
  logic                   en_d, inv_d, pol_d;
  logic [NCH-1:0]         chk_d, ien_d, rg_d, rr_d, pend_d;
  logic [NCH-1:0][DW-1:0] alm_d, sht_d, dat_d, data_q;
  logic [DBW-1:0]         dba_d, dbs_d;
  logic [PW-1:0]          pn_d, ph_d;
  logic                   unused_wd;

  assign unused_wd = ^bus_wdata;

  always_comb begin
    en_d = ctl_en;  inv_d = ctl_inv;  pol_d = ctl_pol;  chk_d = shut_chk;
    ien_d = irq_en; rg_d = route_gpio; rr_d = route_rst; pend_d = pend;
    alm_d = thr_alm; sht_d = thr_sht; dat_d = data_q;
    dba_d = db_alm; dbs_d = db_sht; pn_d = per_norm; ph_d = per_hot;
    if (bus_wr) begin
      case (bus_addr)
        A_CTL: begin
          en_d  = bus_wdata[0];
          inv_d = bus_wdata[1];
          pol_d = bus_wdata[8];
          chk_d = bus_wdata[4 +: NCH];
        end
        A_IEN: begin
          ien_d = bus_wdata[0 +: NCH];
          rg_d  = bus_wdata[4 +: NCH];
          rr_d  = bus_wdata[8 +: NCH];
        end
        A_PEND: pend_d = pend & bus_wdata[NCH-1:0];
        A_DBA:  dba_d  = bus_wdata[DBW-1:0];
        A_DBS:  dbs_d  = bus_wdata[DBW-1:0];
        A_PN:   pn_d   = bus_wdata[PW-1:0];
        A_PH:   ph_d   = bus_wdata[PW-1:0];
        default: ;
      endcase
      for (int n = 0; n < NCH; n++) begin
        if (bus_addr == A_ALM + 8'(4 * n)) alm_d[n] = bus_wdata[DW-1:0];
        if (bus_addr == A_SHT + 8'(4 * n)) sht_d[n] = bus_wdata[DW-1:0];
      end
    end
    pend_d = pend_d | alarm_set;
    if (smp_vld) dat_d[smp_ch] = smp_code;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTL: begin
        bus_rdata[0]        = ctl_en;
        bus_rdata[1]        = ctl_inv;
        bus_rdata[8]        = ctl_pol;
        bus_rdata[4 +: NCH] = shut_chk;
      end
      A_IEN: begin
        bus_rdata[0 +: NCH] = irq_en;
        bus_rdata[4 +: NCH] = route_gpio;
        bus_rdata[8 +: NCH] = route_rst;
      end
      A_PEND: bus_rdata[NCH-1:0] = pend;
      A_DBA:  bus_rdata[DBW-1:0] = db_alm;
      A_DBS:  bus_rdata[DBW-1:0] = db_sht;
      A_PN:   bus_rdata[PW-1:0]  = per_norm;
      A_PH:   bus_rdata[PW-1:0]  = per_hot;
      default: ;
    endcase
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == A_DATA + 8'(4 * n)) bus_rdata[DW-1:0] = data_q[n];
      if (bus_addr == A_ALM + 8'(4 * n))  bus_rdata[DW-1:0] = thr_alm[n];
      if (bus_addr == A_SHT + 8'(4 * n))  bus_rdata[DW-1:0] = thr_sht[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en <= 1'b0; ctl_inv <= 1'b0; ctl_pol <= 1'b0; shut_chk <= '0;
      irq_en <= '0; route_gpio <= '0; route_rst <= '0; pend <= '0;
      thr_alm <= '0; thr_sht <= '0; data_q <= '0;
      db_alm <= DBW'(4); db_sht <= DBW'(4);
      per_norm <= '0; per_hot <= '0;
    end else begin
      ctl_en <= en_d; ctl_inv <= inv_d; ctl_pol <= pol_d; shut_chk <= chk_d;
      irq_en <= ien_d; route_gpio <= rg_d; route_rst <= rr_d; pend <= pend_d;
      thr_alm <= alm_d; thr_sht <= sht_d; data_q <= dat_d;
      db_alm <= dba_d; db_sht <= dbs_d;
      per_norm <= pn_d; per_hot <= ph_d;
    end
  end
endmodule

// File: rtl/tsc_seq.sv
module tsc_seq
  import tsc_pkg::*;
#(
  parameter int NCH = 2,
  parameter int PW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           tick,
  input  logic           hot,
  input  logic [PW-1:0]  per_norm,
  input  logic [PW-1:0]  per_hot,
  input  logic           adc_ack,
  output logic           adc_req,
  output logic [CHW-1:0] adc_chan,
  output logic           smp_vld
);
  sq_state_e      state_q, state_d;
  logic [PW-1:0]  cnt_q, cnt_d, per_sel, per_eff;
  logic [CHW-1:0] ch_q, ch_d;

  assign per_sel = hot ? per_hot : per_norm;
  assign per_eff = (per_sel == '0) ? PW'(1) : per_sel;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ch_d    = ch_q;
    if (!en) begin
      state_d = SQ_IDLE;
      cnt_d   = '0;
      ch_d    = '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          state_d = SQ_WAIT;
          cnt_d   = '0;
        end
        SQ_WAIT: if (tick) begin
          if (cnt_q == per_eff - PW'(1)) begin
            state_d = SQ_REQ;
            cnt_d   = '0;
            ch_d    = '0;
          end else begin
            cnt_d = cnt_q + PW'(1);
          end
        end
        SQ_REQ: if (adc_ack) begin
          if (ch_q == CHW'(NCH - 1)) begin
            state_d = SQ_WAIT;
            ch_d    = '0;
          end else begin
            ch_d = ch_q + CHW'(1);
          end
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      ch_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ch_q    <= ch_d;
    end
  end

  assign adc_req  = (state_q == SQ_REQ);
  assign adc_chan = ch_q;
  assign smp_vld  = adc_req && adc_ack;
endmodule

// File: rtl/tsc_chan_mon.sv
module tsc_chan_mon #(
  parameter int DW     = 12,
  parameter int DBW    = 4,
  parameter bit HOT_UP = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           smp,
  input  logic [DW-1:0]  code,
  input  logic [DW-1:0]  thr_alm,
  input  logic [DW-1:0]  thr_sht,
  input  logic [DBW-1:0] db_alm,
  input  logic [DBW-1:0] db_sht,
  input  logic           chk,
  output logic           alarm_set,
  output logic           shut_act,
  output logic           over
);
  logic           exc_a, exc_s;
  logic [DBW-1:0] ca_q, ca_d, cs_q, cs_d, ca_nxt, cs_nxt, dba_eff, dbs_eff;
  logic           lat_d, over_d;

  generate
    if (HOT_UP) begin : g_up
      assign exc_a = code > thr_alm;
      assign exc_s = code > thr_sht;
    end else begin : g_down
      assign exc_a = code < thr_alm;
      assign exc_s = code < thr_sht;
    end
  endgenerate

  assign dba_eff = (db_alm == '0) ? DBW'(1) : db_alm;
  assign dbs_eff = (db_sht == '0) ? DBW'(1) : db_sht;
  assign ca_nxt  = (&ca_q) ? ca_q : ca_q + DBW'(1);
  assign cs_nxt  = (&cs_q) ? cs_q : cs_q + DBW'(1);

  always_comb begin
    ca_d      = ca_q;
    cs_d      = cs_q;
    lat_d     = shut_act;
    over_d    = over;
    alarm_set = 1'b0;
    if (!en) begin
      ca_d   = '0;
      cs_d   = '0;
      lat_d  = 1'b0;
      over_d = 1'b0;
    end else if (smp) begin
      ca_d      = exc_a ? ca_nxt : '0;
      cs_d      = exc_s ? cs_nxt : '0;
      alarm_set = exc_a && (ca_nxt >= dba_eff);
      lat_d     = shut_act | (chk && exc_s && (cs_nxt >= dbs_eff));
      over_d    = exc_a | exc_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ca_q     <= '0;
      cs_q     <= '0;
      shut_act <= 1'b0;
      over     <= 1'b0;
    end else begin
      ca_q     <= ca_d;
      cs_q     <= cs_d;
      shut_act <= lat_d;
      over     <= over_d;
    end
  end
endmodule

// File: rtl/thermal_scan_ctrl.sv
module thermal_scan_ctrl #(
  parameter int NCH    = 2,
  parameter int DW     = 12,
  parameter int PW     = 16,
  parameter int DBW    = 4,
  parameter bit HOT_UP = 1'b1,
  localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic           bus_wr,
  input  logic [7:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           adc_req,
  output logic [CHW-1:0] adc_chan,
  input  logic           adc_ack,
  input  logic [DW-1:0]  adc_code,
  output logic           irq,
  output logic           shut_gpio,
  output logic           shut_rst
);
  logic                   ctl_en, ctl_inv, ctl_pol, smp_vld, hot;
  logic [NCH-1:0]         shut_chk, irq_en, route_gpio, route_rst, pend;
  logic [NCH-1:0]         alarm_set, shut_act, over;
  logic [NCH-1:0][DW-1:0] thr_alm, thr_sht;
  logic [DBW-1:0]         db_alm, db_sht;
  logic [PW-1:0]          per_norm, per_hot;
  logic [31:0]            inv_full;
  logic [DW-1:0]          code_st;
  logic                   gpio_act, rst_act;

  assign inv_full = 32'd1024 - 32'(adc_code);
  assign code_st  = ctl_inv ? inv_full[DW-1:0] : adc_code;

  tsc_regs #(.NCH(NCH), .DW(DW), .PW(PW), .DBW(DBW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .smp_vld(smp_vld), .smp_ch(adc_chan), .smp_code(code_st),
    .alarm_set(alarm_set), .ctl_en(ctl_en), .ctl_inv(ctl_inv),
    .ctl_pol(ctl_pol), .shut_chk(shut_chk), .irq_en(irq_en),
    .route_gpio(route_gpio), .route_rst(route_rst), .pend(pend),
    .thr_alm(thr_alm), .thr_sht(thr_sht), .db_alm(db_alm),
    .db_sht(db_sht), .per_norm(per_norm), .per_hot(per_hot)
  );

  tsc_seq #(.NCH(NCH), .PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(ctl_en), .tick(tick_en), .hot(hot),
    .per_norm(per_norm), .per_hot(per_hot), .adc_ack(adc_ack),
    .adc_req(adc_req), .adc_chan(adc_chan), .smp_vld(smp_vld)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_mon
      tsc_chan_mon #(.DW(DW), .DBW(DBW), .HOT_UP(HOT_UP)) u_mon (
        .clk(clk), .rst_n(rst_n), .en(ctl_en),
        .smp(smp_vld && (adc_chan == CHW'(g))), .code(code_st),
        .thr_alm(thr_alm[g]), .thr_sht(thr_sht[g]),
        .db_alm(db_alm), .db_sht(db_sht), .chk(shut_chk[g]),
        .alarm_set(alarm_set[g]), .shut_act(shut_act[g]), .over(over[g])
      );
    end
  endgenerate

  assign hot       = |over;
  assign irq       = |(pend & irq_en);
  assign gpio_act  = |(shut_act & route_gpio);
  assign rst_act   = |(shut_act & route_rst);
  assign shut_gpio = ctl_pol ? gpio_act : ~gpio_act;
  assign shut_rst  = ctl_pol ? rst_act : ~rst_act;
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int NCH = 2,
  parameter int CHW = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           pol,
  input logic           bus_wr,
  input logic           adc_req,
  input logic           adc_ack,
  input logic [CHW-1:0] adc_chan,
  input logic           shut_gpio,
  input logic [NCH-1:0] pend
);
  // R9: a disabled block issues no request in the following cycle
  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !adc_req);

  // R9: a disabled block parks the shutdown pin at its inactive level
  p_pin_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !bus_wr) |=> (shut_gpio == !pol));

  // R2: an unanswered request stays up on the same channel
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req && !adc_ack && en) |=> (adc_req && $stable(adc_chan)));

  // R4: a pending bit only appears right after a converter sample
  p_pend_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) != '0) |-> $past(adc_ack));
endmodule

bind thermal_scan_ctrl tsc_checker #(.NCH(NCH), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctl_en), .pol(ctl_pol), .bus_wr(bus_wr),
  .adc_req(adc_req), .adc_ack(adc_ack), .adc_chan(adc_chan),
  .shut_gpio(shut_gpio), .pend(pend)
);

// File: tb/sim_thermal_scan_ctrl.sv
module sim_thermal_scan_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, tick_en, bus_wr, adc_ack, irq, shut_gpio, shut_rst;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        adc_req;
  logic [0:0]  adc_chan;
  logic [11:0] adc_code;

  int checks = 0, errors = 0;
  int rounds = 0, nlog = 0;
  int log_ch [4];
  int gap_t = 0, gap_c = 0, last_gap_t = 0, last_gap_c = 0;
  bit prev_req = 0, tick_alt = 0;
  logic [11:0] mcode [2];

  thermal_scan_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .adc_req(adc_req), .adc_chan(adc_chan), .adc_ack(adc_ack),
    .adc_code(adc_code), .irq(irq), .shut_gpio(shut_gpio), .shut_rst(shut_rst)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // converter model, tick source and gap monitor
  initial begin
    tick_en = 1'b1; adc_ack = 1'b0; adc_code = '0;
    forever begin
      @(negedge clk);
      tick_en = tick_alt ? ~tick_en : 1'b1;
      if (!adc_req) begin
        gap_c++;
        if (tick_en) gap_t++;
      end else if (!prev_req) begin
        last_gap_t = gap_t; last_gap_c = gap_c; gap_t = 0; gap_c = 0;
      end
      prev_req = adc_req;
      if (adc_req && !adc_ack) begin
        adc_ack  = 1'b1;
        adc_code = mcode[adc_chan];
        if (nlog < 4) begin log_ch[nlog] = int'(adc_chan); nlog++; end
        if (adc_chan == 1'b1) rounds++;
      end else begin
        adc_ack = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_rounds(input int k);
    int target;
    target = rounds + k;
    while (rounds < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic quiet(input int pn, input int ph);
    wr(8'h04, 32'h0);
    wr(8'h08, 32'h0);
    wr(8'h0C, 32'h0);
    wr(8'h30, 32'hFFF); wr(8'h34, 32'hFFF);
    wr(8'h40, 32'hFFF); wr(8'h44, 32'hFFF);
    wr(8'h68, pn); wr(8'h6C, ph);
    mcode[0] = 12'h100; mcode[1] = 12'h100;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", int'(irq), 0);
    chk("R1 adc_req", int'(adc_req), 0);
    chk("R1 shut_gpio", int'(shut_gpio), 1);
    chk("R1 shut_rst", int'(shut_rst), 1);
    rd(8'h04, d); chk("R1 control", int'(d), 0);
    rd(8'h60, d); chk("R1 alarm debounce", int'(d), 4);
  endtask

  task automatic t_scan;
    logic [31:0] d;
    quiet(8, 8);
    mcode[0] = 12'h123; mcode[1] = 12'hABC;
    nlog = 0;
    wr(8'h04, 32'h1);
    wait_rounds(2);
    chk("R2 first channel", log_ch[0], 0);
    chk("R2 second channel", log_ch[1], 1);
    chk("R2 next scan channel", log_ch[2], 0);
    rd(8'h20, d); chk("R3 data ch0", int'(d), 32'h123);
    rd(8'h24, d); chk("R3 data ch1", int'(d), 32'hABC);
    chk("R3 upper bits zero", int'(d[31:12]), 0);
  endtask

  task automatic t_invert;
    logic [31:0] d;
    mcode[0] = 12'd100;
    wr(8'h04, 32'h3);
    wait_rounds(2);
    rd(8'h20, d); chk("R3 inverted data", int'(d), 924);
    wr(8'h04, 32'h1);
    wait_rounds(2);
    rd(8'h20, d); chk("R3 plain data", int'(d), 100);
  endtask

  task automatic t_period;
    quiet(6, 3);
    wr(8'h30, 32'h400);
    wr(8'h04, 32'h1);
    wait_rounds(3);
    chk("R6 normal gap", last_gap_t, 6);
    mcode[0] = 12'h500;
    wait_rounds(3);
    chk("R6 hot gap", last_gap_t, 3);
    mcode[0] = 12'h100;
    wait_rounds(3);
    chk("R6 back to normal gap", last_gap_t, 6);
    tick_alt = 1;
    wait_rounds(3);
    chk("R10 gap counts ticks", last_gap_t, 6);
    chk("R10 gap stretches in cycles", int'(last_gap_c >= 11), 1);
    tick_alt = 0;
  endtask

  task automatic t_alarm;
    logic [31:0] d;
    quiet(10, 10);
    wr(8'h60, 32'h3);
    wr(8'h30, 32'h500);
    wr(8'h08, 32'h1);
    mcode[0] = 12'h600;
    wr(8'h04, 32'h1);
    wait_rounds(2);
    rd(8'h0C, d); chk("R4 no pending after 2", int'(d), 0);
    chk("R5 irq low", int'(irq), 0);
    wait_rounds(1);
    rd(8'h0C, d); chk("R4 pending after 3", int'(d), 1);
    chk("R5 irq high", int'(irq), 1);
    mcode[0] = 12'h100;
    wait_rounds(1);
    wr(8'h0C, 32'h3);
    rd(8'h0C, d); chk("R5 write one keeps", int'(d), 1);
    wr(8'h08, 32'h0);
    chk("R5 masked irq", int'(irq), 0);
    wr(8'h08, 32'h1);
    chk("R5 unmasked irq", int'(irq), 1);
    wr(8'h0C, 32'h0);
    rd(8'h0C, d); chk("R5 write zero clears", int'(d), 0);
    chk("R5 irq after clear", int'(irq), 0);
    mcode[0] = 12'h600;
    wait_rounds(2);
    mcode[0] = 12'h100;
    wait_rounds(1);
    mcode[0] = 12'h600;
    wait_rounds(2);
    rd(8'h0C, d); chk("R4 count restarts", int'(d), 0);
    wait_rounds(1);
    rd(8'h0C, d); chk("R4 pending after restart", int'(d), 1);
  endtask

  task automatic t_shutdown;
    quiet(10, 10);
    wr(8'h64, 32'h2);
    wr(8'h44, 32'h700);
    wr(8'h08, 32'h20);
    mcode[1] = 12'h800;
    wr(8'h04, 32'h21);
    wait_rounds(1);
    chk("R7 gpio idle after 1", int'(shut_gpio), 1);
    wait_rounds(1);
    chk("R7 gpio active low", int'(shut_gpio), 0);
    chk("R7 rst not routed", int'(shut_rst), 1);
    wr(8'h04, 32'h0);
    wr(8'h04, 32'h1);
    wait_rounds(3);
    chk("R8 no check no shutdown", int'(shut_gpio), 1);
    wr(8'h04, 32'h0);
    wr(8'h08, 32'h200);
    wr(8'h04, 32'h121);
    chk("R7 rst idle high-active", int'(shut_rst), 0);
    wait_rounds(2);
    chk("R7 rst active high", int'(shut_rst), 1);
    chk("R7 gpio not routed", int'(shut_gpio), 0);
  endtask

  task automatic t_disable;
    bit seen;
    wr(8'h04, 32'h100);
    @(negedge clk);
    chk("R9 rst pin inactive", int'(shut_rst), 0);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (adc_req) seen = 1;
    end
    chk("R9 no requests", int'(seen), 0);
    wr(8'h04, 32'h121);
    wait_rounds(1);
    chk("R9 debounce restarted", int'(shut_rst), 0);
    wait_rounds(1);
    chk("R9 shutdown after restart", int'(shut_rst), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog R1-timeout actual=%0d expected=%0d", rounds, -1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    mcode[0] = '0; mcode[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_scan;
    t_invert;
    t_period;
    t_alarm;
    t_shutdown;
    t_disable;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule